// File: doc/BRIEF.md
# I2C Target Address and Acknowledge Controller

This block sits on the target side of an I2C bus. It oversamples SCL and SDA on a fast system clock and recognises START, repeated START and STOP conditions. It shifts in each byte and compares the first byte after any START with a programmable address, using either 7-bit or 10-bit addressing and a per-bit compare mask. It then drives the acknowledge in the ninth clock slot.

The acknowledge comes from hardware by default. In hold mode software inspects each byte while the block holds SCL low, and the ACK level is taken from a control bit when software releases the bus. In 10-bit mode the block holds SCL after every address byte until software rewrites the address register. Software reaches the block through a small write port, a buffer-read strobe, status flags and one interrupt line.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP clears `addressed`, `rd_req` and any completed 10-bit match. When control bit 3 is set, START, repeated START and STOP each set `irq`; when it is clear, they do not.
- R2: In 7-bit mode (control bit 0 = 0) the first byte after a START matches when byte bits [7:1] equal address bits [7:1] wherever mask bit = 1. A mask bit of 0 is a don't-care, and byte bit 0 (R/W) is excluded from the compare. On a match the byte is loaded into `rx_data`, `buf_full` and `irq` are set, `addressed` goes high, `rd_req` equals byte bit 0, and `sda_oe` pulls SDA low for the ninth clock.
- R3: An address byte that does not match gets no ACK, sets no flag and raises no interrupt. Every following byte is also ignored until the next START.
- R4: Each data byte that follows a write match is acknowledged and loaded into `rx_data`, provided the buffer is empty.
- R5: When `buf_full` or `overflow` is already set as a byte arrives, that byte gets no ACK and `rx_data` keeps its value. If the byte would otherwise have been accepted, `overflow` is set.
- R6: With control bit 1 (address hold) or control bit 2 (data hold) set for the byte type, the block sets `ack_time` and `irq` at the 8th falling SCL edge and holds SCL low (`scl_oe` = 1). It waits for command bit 0, then drives ACK when control bit 4 = 0 and NACK when it is 1. `ack_time` clears at the end of the ACK slot and is never set while both hold bits are clear.
- R7: In 10-bit mode (control bit 0 = 1) a write high byte matches when it equals 1,1,1,1,0,A9,A8,0, where A9 and A8 are address bits 2 and 1. After its ACK slot `upd_addr` is set and SCL is held low. Any write to the address register clears `upd_addr` and releases SCL.
- R8: The 10-bit low byte is compared on all 8 bits (masked). Whether or not it matches, `irq` and `upd_addr` are set after its ACK slot and SCL is held low until the address register is written. Only a match is acknowledged and enters the data phase.
- R9: A 10-bit high byte with R/W = 1 after a repeated START is acknowledged, and raises `rd_req`, only if a full high-plus-low write match has occurred since the last STOP. Otherwise it is not acknowledged.
- R10: Write port, selected by `reg_sel`: 0 = address, 1 = mask, 2 = control, 3 = command. Command bits: bit 0 = release the hold, bit 1 = clear `irq`, bit 2 = clear `overflow`. `buf_rd` clears `buf_full`. After reset the address is 0, the mask is 8'hFF, the control bits are 0, every flag is 0, and neither bus line is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 mask, 2 control, 3 command |
| reg_wdata | input | 8 | Register write data |
| buf_rd | input | 1 | Receive buffer read strobe, clears `buf_full` |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| upd_addr | output | 1 | 10-bit address register update pending |
| ack_time | output | 1 | Waiting in the acknowledge window for software |
| addressed | output | 1 | Target is selected |
| rd_req | output | 1 | Target was selected for a read |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a 10-bit read. It needs a write high byte, a stretched pause, a rewrite of the address register, a matching low byte, a second stretched pause, a restore of the high byte, and then a repeated START carrying R/W = 1. The bench's bus model waits out each stretch while the main thread performs the register writes in the order this handshake needs. A second pass sends a wrong low byte and then tries the read again after a STOP, to show that the read is refused. Hold-mode bytes run a bus thread and a software thread in parallel: the software thread releases the stretched clock only after it has checked `ack_time`.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types and constants for the I2C target controller.
// Assumes 8-bit bytes; the control and command bit positions below are the
// software-visible encodings.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_LO,
        ST_DATA,
        ST_READ
    } tgt_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_CMD  = 2'd3;

    localparam int CTL_W     = 5;
    localparam int CTL_TEN   = 0;
    localparam int CTL_AHOLD = 1;
    localparam int CTL_DHOLD = 2;
    localparam int CTL_CIRQ  = 3;
    localparam int CTL_ACKV  = 4;

    localparam int CMD_REL    = 0;
    localparam int CMD_CLRIRQ = 1;
    localparam int CMD_CLROV  = 2;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: i2c_tgt_sync
// Brings SCL and SDA into the clock domain through SYNC_STAGES flops and
// flags SCL edges and START/STOP conditions. Assumes the system clock runs at
// least 8x the SCL rate, so each bus phase spans several samples.
module i2c_tgt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;
    logic             scl_s;
    logic             scl_prev;
    logic             sda_prev;

    // Shift both lines through the synchroniser chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    assign scl_s    = scl_p[SYNC_STAGES-1];
    assign scl_prev = scl_p[SYNC_STAGES];
    assign sda_s    = sda_p[SYNC_STAGES-1];
    assign sda_prev = sda_p[SYNC_STAGES];

    // Edge and bus condition pulses from the current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_shift.sv
// Module: i2c_tgt_shift
// Counts SCL edges within a byte, shifts in SDA on each rising edge and marks
// the 8th falling edge (byte complete) and the 9th falling edge (end of the
// acknowledge slot). Assumes a START or STOP restarts the count.
module i2c_tgt_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              slot_done
);
    localparam int                CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  SLOT  = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;

    // Bit counter and shift register for one byte plus its ACK slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else if (scl_rise && (cnt < LAST)) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
        end else if (scl_fall && (cnt == LAST)) begin
            cnt <= SLOT;
        end else if (scl_fall && (cnt == SLOT)) begin
            cnt <= '0;
        end
    end

    assign rx_byte   = sh;
    assign byte_done = scl_fall && (cnt == LAST);
    assign slot_done = scl_fall && (cnt == SLOT);
endmodule

// File: rtl/i2c_tgt_match.sv
// Module: i2c_tgt_match
// Combinational address comparator. A mask bit of 0 makes the matching
// address bit a don't-care. Assumes 8-bit bytes for the 10-bit prefix layout.
module i2c_tgt_match
    import i2c_tgt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] mask_i,
    output logic              hit7,
    output logic              hit10_hi,
    output logic              hit10_lo,
    output logic              rw
);
    logic [BYTE_W-2:0] hi_pat;
    logic [BYTE_W-2:0] hi_msk;

    // Form the expected 10-bit high-byte pattern and its mask.
    always_comb begin
        hi_pat = {TEN_PREFIX, addr_i[2:1]};
        hi_msk = {5'b11111, mask_i[2:1]};
    end

    // Evaluate the three compares; bit 0 is R/W except for the low byte.
    always_comb begin
        hit7     = ((byte_i[BYTE_W-1:1] ^ addr_i[BYTE_W-1:1]) & mask_i[BYTE_W-1:1]) == '0;
        hit10_hi = ((byte_i[BYTE_W-1:1] ^ hi_pat) & hi_msk) == '0;
        hit10_lo = ((byte_i ^ addr_i) & mask_i) == '0;
        rw       = byte_i[0];
    end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: i2c_tgt_ctrl (top)
// I2C target controller: address phase sequencing, acknowledge generation,
// clock stretching for hold mode and 10-bit address updates, and the
// software register port. Assumes the bus lines are open drain: the *_oe
// outputs pull the line low when high.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              buf_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              ack_time,
    output logic              addressed,
    output logic              rd_req,
    output logic              irq
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done, slot_done;
    logic              hit7, hit10_hi, hit10_lo, rw;

    tgt_state_t        state, nxt;
    logic [BYTE_W-1:0] addr_q, mask_q, buf_q;
    logic [CTL_W-1:0]  ctrl_q;
    logic              ack_drv, hold_wait, rel_pend, ua_pend, ten_ok;
    logic              acc, set_ua, lo_stage, set_ten, clr_ten, is_addr;
    logic              hold_en, full;

    i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .rx_byte(rx_byte), .byte_done(byte_done), .slot_done(slot_done)
    );

    i2c_tgt_match #(.BYTE_W(BYTE_W)) u_match (
        .byte_i(rx_byte), .addr_i(addr_q), .mask_i(mask_q),
        .hit7(hit7), .hit10_hi(hit10_hi), .hit10_lo(hit10_lo), .rw(rw)
    );

    // Decide the outcome of a completed byte for the current phase.
    always_comb begin
        acc      = 1'b0;
        nxt      = ST_IDLE;
        set_ua   = 1'b0;
        lo_stage = 1'b0;
        set_ten  = 1'b0;
        clr_ten  = 1'b0;
        is_addr  = 1'b1;
        case (state)
            ST_ADDR: begin
                if (ctrl_q[CTL_TEN]) begin
                    if (hit10_hi && !rw) begin
                        acc     = 1'b1;
                        nxt     = ST_ADDR_LO;
                        set_ua  = 1'b1;
                        clr_ten = 1'b1;
                    end else if (hit10_hi && rw && ten_ok) begin
                        acc = 1'b1;
                        nxt = ST_READ;
                    end
                end else if (hit7) begin
                    acc = 1'b1;
                    nxt = rw ? ST_READ : ST_DATA;
                end
            end
            ST_ADDR_LO: begin
                lo_stage = 1'b1;
                set_ua   = 1'b1;
                if (hit10_lo) begin
                    acc     = 1'b1;
                    nxt     = ST_DATA;
                    set_ten = 1'b1;
                end
            end
            ST_DATA: begin
                acc     = 1'b1;
                nxt     = ST_DATA;
                is_addr = 1'b0;
            end
            default: nxt = state;
        endcase
        hold_en = is_addr ? ctrl_q[CTL_AHOLD] : ctrl_q[CTL_DHOLD];
        full    = buf_full || overflow;
    end

    // Register port, bus events, acknowledge and stretch control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            mask_q    <= '1;
            ctrl_q    <= '0;
            buf_q     <= '0;
            buf_full  <= 1'b0;
            overflow  <= 1'b0;
            irq       <= 1'b0;
            upd_addr  <= 1'b0;
            ack_time  <= 1'b0;
            ack_drv   <= 1'b0;
            hold_wait <= 1'b0;
            rel_pend  <= 1'b0;
            ua_pend   <= 1'b0;
            ten_ok    <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_sel)
                    SEL_ADDR: addr_q <= reg_wdata;
                    SEL_MASK: mask_q <= reg_wdata;
                    SEL_CTRL: ctrl_q <= reg_wdata[CTL_W-1:0];
                    default: begin
                        if (reg_wdata[CMD_CLRIRQ]) irq      <= 1'b0;
                        if (reg_wdata[CMD_CLROV])  overflow <= 1'b0;
                        if (reg_wdata[CMD_REL] && hold_wait && !rel_pend) begin
                            ack_drv  <= ~ctrl_q[CTL_ACKV];
                            rel_pend <= 1'b1;
                        end
                    end
                endcase
            end
            if (buf_rd) buf_full <= 1'b0;
            if (rel_pend) begin
                hold_wait <= 1'b0;
                rel_pend  <= 1'b0;
            end
            if (start_det || stop_det) begin
                state     <= start_det ? ST_ADDR : ST_IDLE;
                if (stop_det) ten_ok <= 1'b0;
                ua_pend   <= 1'b0;
                ack_drv   <= 1'b0;
                hold_wait <= 1'b0;
                rel_pend  <= 1'b0;
                ack_time  <= 1'b0;
                if (ctrl_q[CTL_CIRQ]) irq <= 1'b1;
            end else begin
                if (byte_done) begin
                    if (set_ua && (lo_stage || !full)) ua_pend <= 1'b1;
                    if (lo_stage) irq <= 1'b1;
                    if (clr_ten) ten_ok <= 1'b0;
                    if (acc && full) begin
                        overflow <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        state <= nxt;
                        if (set_ten) ten_ok <= 1'b1;
                        if (acc) begin
                            buf_q    <= rx_byte;
                            buf_full <= 1'b1;
                            irq      <= 1'b1;
                            if (hold_en) begin
                                hold_wait <= 1'b1;
                                ack_time  <= 1'b1;
                            end else begin
                                ack_drv <= 1'b1;
                            end
                        end
                    end
                end
                if (slot_done) begin
                    ack_drv  <= 1'b0;
                    ack_time <= 1'b0;
                    if (ua_pend) begin
                        upd_addr <= 1'b1;
                        ua_pend  <= 1'b0;
                    end
                end
            end
            if (reg_we && (reg_sel == SEL_ADDR)) upd_addr <= 1'b0;
        end
    end

    assign scl_oe    = hold_wait | upd_addr;
    assign sda_oe    = ack_drv;
    assign rx_data   = buf_q;
    assign addressed = (state == ST_DATA) || (state == ST_READ);
    assign rd_req    = (state == ST_READ);
endmodule

// File: rtl/i2c_tgt_chk.sv
// Module: i2c_tgt_chk
// Protocol checker bound to i2c_tgt_ctrl. Assumes a reset is applied first.
module i2c_tgt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       upd_addr,
    input logic       ack_time,
    input logic       addressed,
    input logic       buf_full,
    input logic       overflow,
    input logic       reg_we,
    input logic [1:0] reg_sel,
    input logic [4:0] ctrl_q,
    input logic       stop_det,
    input logic       byte_done
);
    AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);                                   // R2
    AST_STOP_DROPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !addressed);                                    // R1
    AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && (buf_full || overflow)) |=> !sda_oe);          // R5
    AST_ACKTIME_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_time) |-> (ctrl_q[1] || ctrl_q[2]));               // R6
    AST_UA_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr) |-> !scl_i);                                 // R7
    AST_ADDR_WR_CLEARS_UA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 2'd0) |=> !upd_addr);                  // R7
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .upd_addr(upd_addr), .ack_time(ack_time), .addressed(addressed),
    .buf_full(buf_full), .overflow(overflow), .reg_we(reg_we),
    .reg_sel(reg_sel), .ctrl_q(ctrl_q), .stop_det(stop_det),
    .byte_done(byte_done)
);

// File: tb/sim_i2c_tgt_ctrl.sv
module sim_i2c_tgt_ctrl;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1;
    logic scl_oe, sda_oe;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic buf_rd = 1'b0;
    logic [7:0] rx_data;
    logic buf_full, overflow, upd_addr, ack_time, addressed, rd_req, irq;
    logic scl_line, sda_line;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign scl_line = scl_drv & ~scl_oe;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_tgt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .buf_rd(buf_rd), .rx_data(rx_data),
        .buf_full(buf_full), .overflow(overflow), .upd_addr(upd_addr),
        .ack_time(ack_time), .addressed(addressed), .rd_req(rd_req), .irq(irq)
    );

    function automatic bit exp_hit7(input [7:0] a, input [7:0] m, input [7:0] b);
        return (((a ^ b) & m & 8'hFE) == 8'h00);
    endfunction

    task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic raise_scl();
        scl_drv = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic wr(input [1:0] s, input [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_buf();
        @(negedge clk); buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0;
    endtask

    task automatic clear_all();
        rd_buf();
        wr(2'd3, 8'h06);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hp();
        raise_scl(); hp();
        sda_drv = 1'b0; hp();
        scl_drv = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hp();
        raise_scl(); hp();
        sda_drv = 1'b1; hp();
    endtask

    task automatic send_byte(input [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; hp();
            raise_scl(); hp();
            scl_drv = 1'b0; hp();
        end
        sda_drv = 1'b1; hp();
        raise_scl(); hp();
        acked = !sda_line;
        scl_drv = 1'b0; hp();
    endtask

    task automatic hold_release(input string tag);
        @(negedge clk);
        while (!scl_oe) @(negedge clk);
        repeat (3) @(negedge clk);
        chk({tag, " ack_time"}, ack_time, 1);
        chk({tag, " irq"}, irq, 1);
        wr(2'd3, 8'h01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        bit ack;
        int seed;
        seed = $urandom(32'd4021);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hp();
        // R10 reset state
        chk("R10 scl_oe", scl_oe, 0);
        chk("R10 sda_oe", sda_oe, 0);
        chk("R10 irq", irq, 0);
        chk("R10 buf_full", buf_full, 0);
        chk("R10 upd_addr", upd_addr, 0);
        chk("R10 addressed", addressed, 0);

        // R2 7-bit match, then R5 overflow on full buffer, then R1 stop
        wr(2'd0, 8'hB4);
        bus_start();
        send_byte(8'hB4, ack);
        chk("R2 ack", ack, 1);
        chk("R2 rx_data", rx_data, 8'hB4);
        chk("R2 buf_full", buf_full, 1);
        chk("R2 irq", irq, 1);
        chk("R2 addressed", addressed, 1);
        chk("R2 rd_req", rd_req, 0);
        send_byte(8'h77, ack);
        chk("R5 nack", ack, 0);
        chk("R5 overflow", overflow, 1);
        chk("R5 rx kept", rx_data, 8'hB4);
        bus_stop();
        chk("R1 stop deselects", addressed, 0);
        clear_all();
        chk("R10 irq cleared", irq, 0);
        chk("R10 ovf cleared", overflow, 0);
        chk("R10 buf cleared", buf_full, 0);

        // R4 data bytes
        bus_start();
        send_byte(8'hB4, ack);
        rd_buf();
        send_byte(8'h3C, ack);
        chk("R4 ack 1", ack, 1);
        chk("R4 rx 1", rx_data, 8'h3C);
        rd_buf();
        send_byte(8'hC3, ack);
        chk("R4 ack 2", ack, 1);
        chk("R4 rx 2", rx_data, 8'hC3);
        bus_stop();
        clear_all();

        // R3 mismatch, later bytes ignored
        bus_start();
        send_byte(8'hB6, ack);
        chk("R3 nack", ack, 0);
        chk("R3 irq", irq, 0);
        chk("R3 buf_full", buf_full, 0);
        send_byte(8'hB4, ack);
        chk("R3 ignored ack", ack, 0);
        chk("R3 ignored buf", buf_full, 0);
        bus_stop();

        // R2 mask don't-care and R/W excluded
        wr(2'd1, 8'hF0);
        bus_start();
        send_byte(8'hB2, ack);
        chk("R2 masked match", ack, 1);
        bus_stop();
        clear_all();
        wr(2'd1, 8'hFF);
        bus_start();
        send_byte(8'hB5, ack);
        chk("R2 rw ignored", ack, 1);
        chk("R2 rd_req", rd_req, 1);
        bus_stop();
        chk("R1 stop clears rd_req", rd_req, 0);
        clear_all();

        // R1 condition interrupts
        wr(2'd2, 8'h08);
        bus_start();
        chk("R1 irq on start", irq, 1);
        wr(2'd3, 8'h02);
        bus_stop();
        chk("R1 irq on stop", irq, 1);
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h00);
        bus_start();
        chk("R1 no irq start", irq, 0);
        bus_stop();
        chk("R1 no irq stop", irq, 0);

        // R6 hold mode, software ACK then NACK
        wr(2'd2, 8'h06);
        bus_start();
        fork
            send_byte(8'hB4, ack);
            hold_release("R6 addr");
        join
        chk("R6 sw ack", ack, 1);
        chk("R6 ack_time cleared", ack_time, 0);
        rd_buf();
        wr(2'd2, 8'h16);
        fork
            send_byte(8'h55, ack);
            hold_release("R6 data");
        join
        chk("R6 sw nack", ack, 0);
        bus_stop();
        clear_all();

        // R7/R8/R9 10-bit write then read
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hF4);
        bus_start();
        send_byte(8'hF4, ack);
        chk("R7 hi ack", ack, 1);
        chk("R7 upd_addr", upd_addr, 1);
        chk("R7 stretch", scl_oe, 1);
        wr(2'd0, 8'h3C);
        chk("R7 upd cleared", upd_addr, 0);
        chk("R7 stretch released", scl_oe, 0);
        rd_buf();
        wr(2'd3, 8'h02);
        send_byte(8'h3C, ack);
        chk("R8 lo ack", ack, 1);
        chk("R8 upd_addr", upd_addr, 1);
        chk("R8 irq", irq, 1);
        chk("R8 addressed", addressed, 1);
        wr(2'd0, 8'hF4);
        rd_buf();
        send_byte(8'h11, ack);
        chk("R4 10-bit data ack", ack, 1);
        chk("R4 10-bit data rx", rx_data, 8'h11);
        rd_buf();
        bus_start();
        send_byte(8'hF5, ack);
        chk("R9 read ack", ack, 1);
        chk("R9 rd_req", rd_req, 1);
        bus_stop();
        clear_all();

        // R8 low mismatch, R9 read refused after stop
        bus_start();
        send_byte(8'hF4, ack);
        wr(2'd0, 8'h3C);
        rd_buf();
        wr(2'd3, 8'h02);
        send_byte(8'h3D, ack);
        chk("R8 lo nack", ack, 0);
        chk("R8 upd on miss", upd_addr, 1);
        chk("R8 stretch on miss", scl_oe, 1);
        chk("R8 irq on miss", irq, 1);
        wr(2'd0, 8'hF4);
        bus_stop();
        clear_all();
        bus_start();
        send_byte(8'hF5, ack);
        chk("R9 read refused", ack, 0);
        chk("R9 no rd_req", rd_req, 0);
        bus_stop();
        clear_all();

        // R2/R3/R4 random 7-bit traffic
        wr(2'd2, 8'h00);
        for (int n = 0; n < 24; n++) begin
            logic [7:0] a, m, b, d;
            bit hit;
            a = 8'($urandom); m = 8'($urandom); d = 8'($urandom);
            b = ($urandom % 2) ? (a ^ (8'($urandom) & ~m)) : 8'($urandom);
            hit = exp_hit7(a, m, b);
            wr(2'd0, a);
            wr(2'd1, m);
            bus_start();
            send_byte(b, ack);
            chk("R2/R3 random ack", ack, hit);
            chk("R2/R3 random buf_full", buf_full, hit);
            if (hit && !b[0]) begin
                rd_buf();
                send_byte(d, ack);
                chk("R4 random ack", ack, 1);
                chk("R4 random rx", rx_data, d);
            end
            bus_stop();
            clear_all();
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule